// File: doc/BRIEF.md
# Debug Address Breakpoint Unit

This block sits beside a processor core and watches two address streams: the instruction fetch address and the load/store address. Software programs five registers through a simple write port: an execute breakpoint address and mask, a data breakpoint address and mask, and a control word. The control word holds the enables for the two comparators and the direction qualifiers for data accesses.

Each incoming address is ANDed with its mask and compared with the programmed breakpoint address. When an enabled comparator hits, a registered one-cycle request is raised in the cycle after the access. The core uses this request to redirect execution to a fixed debug vector, which the block also drives. The execute and data comparators work independently, and both may be enabled at once. If both hit on the same access cycle, only one request is raised.

Top module: `bkpt_unit`

## Requirements
- R1: After reset all five registers hold zero, `brk_req` is low, and reading the control register (select 4) returns 0xE0800000.
- R2: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_sel`, and the value is visible on `rd_data` in the next cycle. The selects are: 0 execute address, 1 execute mask, 2 data address, 3 data mask, 4 control. Selects 5 to 7 store nothing and read 0.
- R3: Only control bits 27:24 are writable. Bits 31:28 always read 1110 and bit 23 always reads 1. All other control bits read 0.
- R4: When control bit 24 is set and `fetch_vld` is high with (`fetch_pc` AND execute mask) equal to the execute address, `brk_req` is high in the following cycle.
- R5: With control bit 24 clear, a matching fetch raises no request.
- R6: When control bit 25 and bit 26 are set, a `dmem_rd` access whose (`dmem_addr` AND data mask) equals the data address raises `brk_req` in the following cycle.
- R7: A matching `dmem_wr` access raises a request only when bits 25 and 27 are both set. A matching access in a direction that is not armed, or with bit 25 clear, raises nothing.
- R8: `brk_req` is a one-cycle pulse for each matching access cycle. It never rises without a strobed access in the previous cycle. Simultaneous execute and data hits give one pulse.
- R9: `brk_vec` always equals 0x00000040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for both write and read |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Read data of the selected register |
| fetch_pc | input | 32 | Instruction fetch address |
| fetch_vld | input | 1 | Fetch address valid |
| dmem_addr | input | 32 | Load/store address |
| dmem_rd | input | 1 | Load access strobe |
| dmem_wr | input | 1 | Store access strobe |
| brk_req | output | 1 | Breakpoint request pulse |
| brk_vec | output | 32 | Debug vector address |

## Verification
A corrupted mask or address register shows up as a missed or spurious `brk_req` on the first strobed access after the corruption. It is also visible at once on `rd_data` when that register is selected. A wrong control nibble shows as a request for a disabled comparator or an unarmed direction, one cycle after the offending access. A broken request register shows as a pulse that lasts two cycles, or as a pulse with no access behind it. The bench therefore samples `brk_req` both in the cycle after each access and in the cycle after that.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int AW      = 32;
    localparam int SEL_W   = 3;
    localparam logic [AW-1:0] DEBUG_VEC = 32'h0000_0040;

    localparam int EN_EXEC_BIT = 24;
    localparam int EN_DATA_BIT = 25;
    localparam int ARM_RD_BIT  = 26;
    localparam int ARM_WR_BIT  = 27;
    localparam logic [AW-1:0] CTL_FIXED = 32'hE080_0000;

    typedef enum logic [SEL_W-1:0] {
        SEL_XADDR = 3'd0,
        SEL_XMASK = 3'd1,
        SEL_DADDR = 3'd2,
        SEL_DMASK = 3'd3,
        SEL_CTRL  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic arm_wr;
        logic arm_rd;
        logic en_data;
        logic en_exec;
    } ctl_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] mask;
    } cmp_cfg_t;

    function automatic logic masked_eq(input logic [AW-1:0] a,
                                       input logic [AW-1:0] m,
                                       input logic [AW-1:0] ref_a);
        return ((a & m) == ref_a);
    endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [AW-1:0]    wdata,
    output logic [AW-1:0]    rdata,
    output cmp_cfg_t         xcfg,
    output cmp_cfg_t         dcfg,
    output ctl_t             ctl
);
    localparam int NWORD = 4;
    logic [AW-1:0] word_q [NWORD];

    for (genvar i = 0; i < NWORD; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                word_q[i] <= '0;
            else if (wr_en && sel == SEL_W'(i))
                word_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (wr_en && sel == SEL_CTRL)
            ctl <= wdata[ARM_WR_BIT:EN_EXEC_BIT];
    end

    assign xcfg = '{addr: word_q[SEL_XADDR], mask: word_q[SEL_XMASK]};
    assign dcfg = '{addr: word_q[SEL_DADDR], mask: word_q[SEL_DMASK]};

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_XADDR, SEL_XMASK, SEL_DADDR, SEL_DMASK: rdata = word_q[sel[1:0]];
            SEL_CTRL: begin
                rdata = CTL_FIXED;
                rdata[ARM_WR_BIT:EN_EXEC_BIT] = ctl;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
(
    input  cmp_cfg_t      cfg,
    input  logic          enable,
    input  logic          strobe,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    assign hit = enable && strobe && masked_eq(addr, cfg.mask, cfg.addr);
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [AW-1:0]    wr_data,
    output logic [AW-1:0]    rd_data,
    input  logic [AW-1:0]    fetch_pc,
    input  logic             fetch_vld,
    input  logic [AW-1:0]    dmem_addr,
    input  logic             dmem_rd,
    input  logic             dmem_wr,
    output logic             brk_req,
    output logic [AW-1:0]    brk_vec
);
    cmp_cfg_t xcfg, dcfg;
    ctl_t     ctl;
    logic     exec_hit, data_hit, data_dir_ok;

    bkpt_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel(wr_sel), .wdata(wr_data),
        .rdata(rd_data), .xcfg(xcfg), .dcfg(dcfg), .ctl(ctl)
    );

    bkpt_cmp u_xcmp (
        .cfg(xcfg), .enable(ctl.en_exec), .strobe(fetch_vld),
        .addr(fetch_pc), .hit(exec_hit)
    );

    assign data_dir_ok = (dmem_rd && ctl.arm_rd) || (dmem_wr && ctl.arm_wr);

    bkpt_cmp u_dcmp (
        .cfg(dcfg), .enable(ctl.en_data), .strobe(data_dir_ok),
        .addr(dmem_addr), .hit(data_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) brk_req <= 1'b0;
        else     brk_req <= exec_hit || data_hit;
    end

    assign brk_vec = DEBUG_VEC;
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk
    import bkpt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [AW-1:0]    wr_data,
    input logic [AW-1:0]    rd_data,
    input logic             fetch_vld,
    input logic             dmem_rd,
    input logic             dmem_wr,
    input logic             brk_req,
    input logic [AW-1:0]    brk_vec,
    input logic             exec_hit,
    input logic             data_hit
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !brk_req);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && $past(wr_sel) == SEL_XADDR && wr_sel == SEL_XADDR && !$past(rst))
        |-> rd_data == $past(wr_data));

    assert_ctl_fixed_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == SEL_CTRL) |-> (rd_data[31:28] == 4'hE && rd_data[23] && rd_data[22:0] == '0));

    assert_exec_strobed_R4: assert property (@(posedge clk) disable iff (rst)
        exec_hit |-> fetch_vld);

    assert_data_strobed_R6: assert property (@(posedge clk) disable iff (rst)
        data_hit |-> (dmem_rd || dmem_wr));

    assert_req_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (brk_req && !$past(rst)) |-> $past(exec_hit || data_hit));

    assert_vector_R9: assert property (@(posedge clk) disable iff (rst)
        brk_vec == DEBUG_VEC);
endmodule

bind bkpt_unit bkpt_unit_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_data(rd_data), .fetch_vld(fetch_vld), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .brk_req(brk_req), .brk_vec(brk_vec), .exec_hit(exec_hit), .data_hit(data_hit)
);

// File: tb/sim_bkpt_unit.sv
`timescale 1ns/1ps
module sim_bkpt_unit;
    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [2:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic [31:0] fetch_pc = 0;
    logic        fetch_vld = 0;
    logic [31:0] dmem_addr = 0;
    logic        dmem_rd = 0;
    logic        dmem_wr = 0;
    logic        brk_req;
    logic [31:0] brk_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bkpt_unit u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(logic [2:0] s, logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rreg(logic [2:0] s, logic [31:0] exp, string req);
        @(negedge clk); wr_sel = s; #1;
        check(req, rd_data, exp);
    endtask

    // one access cycle; check the pulse and its end
    task automatic access(logic fv, logic [31:0] pc, logic rd, logic wr,
                          logic [31:0] da, logic exp, string req);
        @(negedge clk);
        fetch_vld = fv; fetch_pc = pc; dmem_rd = rd; dmem_wr = wr; dmem_addr = da;
        @(posedge clk); #1;
        check(req, {31'd0, brk_req}, {31'd0, exp});
        @(negedge clk);
        fetch_vld = 0; dmem_rd = 0; dmem_wr = 0;
        @(posedge clk); #1;
        check({req, " single pulse R8"}, {31'd0, brk_req}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 req", {31'd0, brk_req}, 32'd0);
        rreg(3'd0, 32'h0, "R1 xaddr");
        rreg(3'd3, 32'h0, "R1 dmask");
        rreg(3'd4, 32'hE080_0000, "R1 ctrl");
        check("R9 vector", brk_vec, 32'h0000_0040);
    endtask

    task automatic t_regs();
        wreg(3'd0, 32'h8001_0000); rreg(3'd0, 32'h8001_0000, "R2 xaddr");
        wreg(3'd1, 32'hFFFF_0000); rreg(3'd1, 32'hFFFF_0000, "R2 xmask");
        wreg(3'd2, 32'h0000_1230); rreg(3'd2, 32'h0000_1230, "R2 daddr");
        wreg(3'd3, 32'hFFFF_FFF0); rreg(3'd3, 32'hFFFF_FFF0, "R2 dmask");
        wreg(3'd6, 32'hDEAD_BEEF); rreg(3'd6, 32'h0, "R2 unused sel");
        rreg(3'd0, 32'h8001_0000, "R2 no side effect");
        wreg(3'd4, 32'h1000_0000); rreg(3'd4, 32'hE080_0000, "R3 fixed bits");
    endtask

    task automatic t_exec();
        access(1, 32'h8001_1234, 0, 0, 0, 0, "R5 disabled");
        wreg(3'd4, 32'h0100_0000);
        access(1, 32'h8001_1234, 0, 0, 0, 1, "R4 masked hit");
        access(1, 32'h8002_1234, 0, 0, 0, 0, "R4 miss");
        access(0, 32'h8001_1234, 0, 0, 0, 0, "R8 no strobe");
    endtask

    task automatic t_data();
        wreg(3'd4, 32'h0600_0000);
        access(0, 0, 1, 0, 32'h0000_123C, 1, "R6 read hit");
        access(0, 0, 0, 1, 32'h0000_123C, 0, "R7 write unarmed");
        access(0, 0, 1, 0, 32'h0000_1240, 0, "R6 miss");
        wreg(3'd4, 32'h0A00_0000);
        access(0, 0, 0, 1, 32'h0000_1238, 1, "R7 write hit");
        access(0, 0, 1, 0, 32'h0000_1238, 0, "R7 read unarmed");
        wreg(3'd4, 32'h0C00_0000);
        access(0, 0, 0, 1, 32'h0000_1238, 0, "R7 data disabled");
    endtask

    task automatic t_both();
        wreg(3'd4, 32'h0F00_0000);
        rreg(3'd4, 32'hEF80_0000, "R3 ctrl readback");
        access(1, 32'h8001_0000, 1, 0, 32'h0000_1230, 1, "R8 both hit");
        access(1, 32'h9000_0000, 0, 1, 32'h0000_1234, 1, "R8 data only");
        access(1, 32'h8001_FFFC, 0, 0, 32'h0, 1, "R4 exec only");
        check("R9 vector", brk_vec, 32'h0000_0040);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_regs();
        t_exec();
        t_data();
        t_both();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule